// File: doc/BRIEF.md
# PLL Calibration Capture and Replay Controller

This controller sits on the memory-mapped reconfiguration port of a transmit PLL. It avoids running a calibration while neighbouring channels carry live traffic. Once after boot, before traffic starts, a capture pass visits every channel and, for each channel, every target rate. For each pair it writes the rate-switch register set into the PLL and starts a calibration. It polls until the calibration ends, reads back the calibrated result registers and keeps the whole set as one record in on-chip RAM. Later, a replay request moves one channel's PLL to a new rate by writing that record back. No calibration is started during a replay.

The rate-switch contents come from an external profile source. The controller presents a channel, rate and word index on `prof_ch`, `prof_rate` and `prof_word`, and the source answers on the same cycle with an address/data pair. A record holds `NSW` rate-switch pairs followed by `NCAL` calibrated pairs. It is stored at index (channel, rate, word) with a valid flag per record. During a replay the channel being switched is held in reset. The replay needs no other precondition, so channel PMA reconfiguration can be done before or after it.

States: `S_IDLE`. Capture: `S_CSW` (write one switch pair), `S_CKICK` (start calibration), `S_CPOLL` (read status), `S_CCHK` (judge status and timeout), `S_CRES` (read one result), `S_CNEXT` (set valid, advance rate then channel), `S_CFIN`, `S_CTOUT`. Replay: `S_RCHK` (valid test), `S_RLOAD` (RAM read), `S_RWR` (write pair), `S_RFIN`. Transitions:
- IDLE→CSW on a capture request; IDLE→RCHK on a replay request.
- CSW→CKICK after the last switch word; CKICK→CPOLL.
- CPOLL→CCHK; CCHK→CRES when calibration is no longer busy, →CTOUT at the time limit, otherwise →CPOLL.
- CRES→CNEXT after the last result; CNEXT→CSW or →CFIN.
- RCHK→RLOAD when the record is valid, →IDLE when it is not; RLOAD→RWR; RWR→RLOAD or →RFIN.
- CFIN, CTOUT and RFIN→IDLE.

Top module: `pll_calrec_ctrl`

## Requirements
- R1: After reset `busy` is 0, every bit of `chan_rst` is 1, no bus command is driven and every record is invalid.
- R2: Capture goes through channels in ascending order and, within a channel, through rates in ascending order. For each pair it does the following in order:
  - writes the `NSW` profile pairs in word order;
  - writes 1 to address `CAL_CTRL_ADDR` (0x040);
  - reads `CAL_STAT_ADDR` (0x041) until bit 0 reads 0;
  - reads `NCAL` results at `CAL_RES_BASE`+k (0x050+k).
- R3: A record stores words 0..NSW-1 as the profile pairs and words NSW..N-1 as the (result address, read value) pairs. Its valid flag is cleared when its capture starts and set only after its last word is stored.
- R4: `busy` is high from the cycle after a request is accepted until the final state of the operation. `cap_done`, `rep_done`, `rep_reject` and `cal_err` are single-cycle pulses, at most one at a time, each while `busy` is high.
- R5: A replay writes the record's N pairs in word order and issues no reads and no write to `CAL_CTRL_ADDR`.
- R6: On a replay request, `chan_rst[ch]` rises at the accepting edge, stays high through every replay write and falls at the edge that ends `rep_done`. Other channel bits are unchanged.
- R7: If the status still reads busy when `TIMEOUT` cycles have passed since the start write, `cal_err` pulses, the capture stops without `cap_done` and the current record stays invalid.
- R8: A replay of an invalid record pulses `rep_reject`, issues no bus command, and leaves `chan_rst[ch]` asserted.
- R9: A command is held with stable address and data while `rc_waitreq` is high. Read data is taken only in a cycle with `rc_rdvalid` high.
- R10: Requests arriving while `busy` is high are ignored.
- R11: If a capture request and a replay request arrive in the same idle cycle, the capture runs and the replay request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cap_req | input | 1 | Start a capture pass (one cycle) |
| rep_req | input | 1 | Start a replay (one cycle) |
| rep_ch | input | CHW | Channel to replay |
| rep_rate | input | RTW | Rate record to replay |
| prof_ch | output | CHW | Profile channel index |
| prof_rate | output | RTW | Profile rate index |
| prof_word | output | WW | Profile word index |
| prof_addr | input | AW | Profile register address |
| prof_data | input | DW | Profile register data |
| rc_addr | output | AW | Reconfiguration address |
| rc_write | output | 1 | Write command |
| rc_read | output | 1 | Read command |
| rc_wdata | output | DW | Write data |
| rc_waitreq | input | 1 | Slave stall |
| rc_rdata | input | DW | Read data |
| rc_rdvalid | input | 1 | Read data valid |
| busy | output | 1 | A phase is running |
| cap_done | output | 1 | Capture pass finished |
| rep_done | output | 1 | Replay finished |
| rep_reject | output | 1 | Replay of invalid record refused |
| cal_err | output | 1 | Calibration timeout |
| chan_rst | output | NCH | Per-channel reset |

## Verification
A capture request and a replay request can land in the same idle cycle, and the sequencer must pick exactly one of them. The bench raises both on one cycle before any record exists. A replay that won would end in `rep_reject`, so the result is judged on four things:
- whether `rep_reject` or `rep_done` ever appears;
- whether the bus traffic matches the full capture sequence;
- whether `cap_done` arrives;
- whether `chan_rst` keeps its value.

A replay request raised in the middle of a later capture is judged the same way.

// File: rtl/pll_calrec_pkg.sv
package pll_calrec_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CSW,
        S_CKICK,
        S_CPOLL,
        S_CCHK,
        S_CRES,
        S_CNEXT,
        S_CFIN,
        S_CTOUT,
        S_RCHK,
        S_RLOAD,
        S_RWR,
        S_RFIN
    } seq_state_t;

    typedef enum logic [1:0] {
        M_IDLE,
        M_CMD,
        M_RESP
    } bm_state_t;

endpackage

// File: rtl/cr_bus_master.sv
module cr_bus_master
    import pll_calrec_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_done,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] rc_addr,
    output logic          rc_write,
    output logic          rc_read,
    output logic [DW-1:0] rc_wdata,
    input  logic          rc_waitreq,
    input  logic [DW-1:0] rc_rdata,
    input  logic          rc_rdvalid
);

    bm_state_t     st, st_nxt;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= M_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (st == M_IDLE && cmd_go) begin
            wr_q   <= cmd_wr;
            addr_q <= cmd_addr;
            data_q <= cmd_wdata;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            M_IDLE: if (cmd_go) st_nxt = M_CMD;
            M_CMD:  if (!rc_waitreq) st_nxt = wr_q ? M_IDLE : M_RESP;
            M_RESP: if (rc_rdvalid) st_nxt = M_IDLE;
            default: st_nxt = M_IDLE;
        endcase
    end

    always_comb begin
        rc_write = (st == M_CMD) && wr_q;
        rc_read  = (st == M_CMD) && !wr_q;
        rc_addr  = addr_q;
        rc_wdata = data_q;
        cmd_done = ((st == M_CMD) && wr_q && !rc_waitreq) ||
                   ((st == M_RESP) && rc_rdvalid);
        rsp_data = rc_rdata;
    end

endmodule

// File: rtl/cr_record_ram.sv
module cr_record_ram #(
    parameter int NREC  = 4,
    parameter int DEPTH = 16,
    parameter int EW    = 44,
    localparam int XW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RIW  = (NREC > 1) ? $clog2(NREC) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [XW-1:0]  idx,
    input  logic [EW-1:0]  wdata,
    output logic [EW-1:0]  rdata,
    input  logic           vset,
    input  logic           vclr,
    input  logic [RIW-1:0] vidx,
    output logic           vout
);

    logic [EW-1:0]   mem [DEPTH];
    logic [NREC-1:0] valid;

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        rdata <= mem[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (vset) begin
            valid[vidx] <= 1'b1;
        end else if (vclr) begin
            valid[vidx] <= 1'b0;
        end
    end

    assign vout = valid[vidx];

endmodule

// File: rtl/cr_sequencer.sv
module cr_sequencer
    import pll_calrec_pkg::*;
#(
    parameter int NCH           = 2,
    parameter int NRATE         = 2,
    parameter int NSW           = 2,
    parameter int NCAL          = 2,
    parameter int AW            = 12,
    parameter int DW            = 32,
    parameter int TIMEOUT       = 4096,
    parameter int CAL_CTRL_ADDR = 'h040,
    parameter int CAL_STAT_ADDR = 'h041,
    parameter int CAL_RES_BASE  = 'h050,
    localparam int N     = NSW + NCAL,
    localparam int NREC  = NCH * NRATE,
    localparam int DEPTH = NREC * N,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RTW   = (NRATE > 1) ? $clog2(NRATE) : 1,
    localparam int WW    = $clog2(N),
    localparam int RIW   = (NREC > 1) ? $clog2(NREC) : 1,
    localparam int XW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EW    = AW + DW,
    localparam int TCW   = $clog2(TIMEOUT + 1) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_req,
    input  logic           rep_req,
    input  logic [CHW-1:0] rep_ch,
    input  logic [RTW-1:0] rep_rate,
    output logic [CHW-1:0] prof_ch,
    output logic [RTW-1:0] prof_rate,
    output logic [WW-1:0]  prof_word,
    input  logic [AW-1:0]  prof_addr,
    input  logic [DW-1:0]  prof_data,
    output logic           cmd_go,
    output logic           cmd_wr,
    output logic [AW-1:0]  cmd_addr,
    output logic [DW-1:0]  cmd_wdata,
    input  logic           cmd_done,
    input  logic [DW-1:0]  rsp_data,
    output logic           ram_we,
    output logic [XW-1:0]  ram_idx,
    output logic [EW-1:0]  ram_wdata,
    input  logic [EW-1:0]  ram_rdata,
    output logic           val_set,
    output logic           val_clr,
    output logic [RIW-1:0] val_idx,
    input  logic           val_in,
    output logic           busy,
    output logic           cap_done,
    output logic           rep_done,
    output logic           rep_reject,
    output logic           cal_err,
    output logic [NCH-1:0] chan_rst,
    output logic           seq_rep,
    output logic [CHW-1:0] cur_ch
);

    seq_state_t     state, nxt;
    logic [CHW-1:0] ch_q;
    logic [RTW-1:0] rate_q;
    logic [WW-1:0]  word_q;
    logic [TCW-1:0] tcnt;
    logic           stat_q;
    logic [NCH-1:0] chrst_q;
    logic [RIW-1:0] rec_idx;
    logic [AW-1:0]  res_addr;
    logic           last_sw, last_word, last_rate, last_ch;

    always_comb begin
        rec_idx   = RIW'(ch_q) * RIW'(NRATE) + RIW'(rate_q);
        ram_idx   = XW'(rec_idx) * XW'(N) + XW'(word_q);
        res_addr  = AW'(CAL_RES_BASE) + AW'(word_q) - AW'(NSW);
        last_sw   = (word_q == WW'(NSW - 1));
        last_word = (word_q == WW'(N - 1));
        last_rate = (rate_q == RTW'(NRATE - 1));
        last_ch   = (ch_q == CHW'(NCH - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (cap_req) nxt = S_CSW;
                     else if (rep_req) nxt = S_RCHK;
            S_CSW:   if (cmd_done && last_sw) nxt = S_CKICK;
            S_CKICK: if (cmd_done) nxt = S_CPOLL;
            S_CPOLL: if (cmd_done) nxt = S_CCHK;
            S_CCHK:  if (!stat_q) nxt = S_CRES;
                     else if (tcnt >= TCW'(TIMEOUT)) nxt = S_CTOUT;
                     else nxt = S_CPOLL;
            S_CRES:  if (cmd_done && last_word) nxt = S_CNEXT;
            S_CNEXT: nxt = (last_rate && last_ch) ? S_CFIN : S_CSW;
            S_CFIN:  nxt = S_IDLE;
            S_CTOUT: nxt = S_IDLE;
            S_RCHK:  nxt = val_in ? S_RLOAD : S_IDLE;
            S_RLOAD: nxt = S_RWR;
            S_RWR:   if (cmd_done) nxt = last_word ? S_RFIN : S_RLOAD;
            S_RFIN:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // counters and channel resets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            rate_q  <= '0;
            word_q  <= '0;
            tcnt    <= '0;
            stat_q  <= 1'b0;
            chrst_q <= '1;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cap_req) begin
                        ch_q   <= '0;
                        rate_q <= '0;
                        word_q <= '0;
                    end else if (rep_req) begin
                        ch_q            <= rep_ch;
                        rate_q          <= rep_rate;
                        word_q          <= '0;
                        chrst_q[rep_ch] <= 1'b1;
                    end
                end
                S_CSW: if (cmd_done) word_q <= word_q + 1'b1;
                S_CKICK: if (cmd_done) tcnt <= '0;
                S_CPOLL: begin
                    if (tcnt < TCW'(TIMEOUT)) tcnt <= tcnt + 1'b1;
                    if (cmd_done) stat_q <= rsp_data[0];
                end
                S_CCHK: if (tcnt < TCW'(TIMEOUT)) tcnt <= tcnt + 1'b1;
                S_CRES: if (cmd_done && !last_word) word_q <= word_q + 1'b1;
                S_CNEXT: begin
                    word_q <= '0;
                    if (last_rate) begin
                        rate_q <= '0;
                        if (!last_ch) ch_q <= ch_q + 1'b1;
                    end else begin
                        rate_q <= rate_q + 1'b1;
                    end
                end
                S_RWR: if (cmd_done && !last_word) word_q <= word_q + 1'b1;
                S_RFIN: chrst_q[ch_q] <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_go    = 1'b0;
        cmd_wr    = 1'b1;
        cmd_addr  = '0;
        cmd_wdata = '0;
        ram_we    = 1'b0;
        ram_wdata = {prof_addr, prof_data};
        unique case (state)
            S_CSW: begin
                cmd_go    = 1'b1;
                cmd_addr  = prof_addr;
                cmd_wdata = prof_data;
                ram_we    = cmd_done;
            end
            S_CKICK: begin
                cmd_go    = 1'b1;
                cmd_addr  = AW'(CAL_CTRL_ADDR);
                cmd_wdata = DW'(1);
            end
            S_CPOLL: begin
                cmd_go   = 1'b1;
                cmd_wr   = 1'b0;
                cmd_addr = AW'(CAL_STAT_ADDR);
            end
            S_CRES: begin
                cmd_go    = 1'b1;
                cmd_wr    = 1'b0;
                cmd_addr  = res_addr;
                ram_we    = cmd_done;
                ram_wdata = {res_addr, rsp_data};
            end
            S_RWR: begin
                cmd_go    = 1'b1;
                cmd_addr  = ram_rdata[EW-1:DW];
                cmd_wdata = ram_rdata[DW-1:0];
            end
            default: ;
        endcase
    end

    always_comb begin
        val_idx    = rec_idx;
        val_clr    = (state == S_CSW) && (word_q == '0);
        val_set    = (state == S_CNEXT);
        busy       = (state != S_IDLE);
        cap_done   = (state == S_CFIN);
        cal_err    = (state == S_CTOUT);
        rep_done   = (state == S_RFIN);
        rep_reject = (state == S_RCHK) && !val_in;
        seq_rep    = (state == S_RCHK) || (state == S_RLOAD) ||
                     (state == S_RWR) || (state == S_RFIN);
        chan_rst   = chrst_q;
        cur_ch     = ch_q;
        prof_ch    = ch_q;
        prof_rate  = rate_q;
        prof_word  = word_q;
    end

endmodule

// File: rtl/pll_calrec_ctrl.sv
module pll_calrec_ctrl #(
    parameter int NCH           = 2,
    parameter int NRATE         = 2,
    parameter int NSW           = 2,
    parameter int NCAL          = 2,
    parameter int AW            = 12,
    parameter int DW            = 32,
    parameter int TIMEOUT       = 4096,
    parameter int CAL_CTRL_ADDR = 'h040,
    parameter int CAL_STAT_ADDR = 'h041,
    parameter int CAL_RES_BASE  = 'h050,
    localparam int N     = NSW + NCAL,
    localparam int NREC  = NCH * NRATE,
    localparam int DEPTH = NREC * N,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RTW   = (NRATE > 1) ? $clog2(NRATE) : 1,
    localparam int WW    = $clog2(N),
    localparam int RIW   = (NREC > 1) ? $clog2(NREC) : 1,
    localparam int XW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EW    = AW + DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_req,
    input  logic           rep_req,
    input  logic [CHW-1:0] rep_ch,
    input  logic [RTW-1:0] rep_rate,
    output logic [CHW-1:0] prof_ch,
    output logic [RTW-1:0] prof_rate,
    output logic [WW-1:0]  prof_word,
    input  logic [AW-1:0]  prof_addr,
    input  logic [DW-1:0]  prof_data,
    output logic [AW-1:0]  rc_addr,
    output logic           rc_write,
    output logic           rc_read,
    output logic [DW-1:0]  rc_wdata,
    input  logic           rc_waitreq,
    input  logic [DW-1:0]  rc_rdata,
    input  logic           rc_rdvalid,
    output logic           busy,
    output logic           cap_done,
    output logic           rep_done,
    output logic           rep_reject,
    output logic           cal_err,
    output logic [NCH-1:0] chan_rst
);

    logic           cmd_go, cmd_wr, cmd_done;
    logic [AW-1:0]  cmd_addr;
    logic [DW-1:0]  cmd_wdata, rsp_data;
    logic           ram_we;
    logic [XW-1:0]  ram_idx;
    logic [EW-1:0]  ram_wdata, ram_rdata;
    logic           val_set, val_clr, val_in;
    logic [RIW-1:0] val_idx;
    logic           seq_rep;
    logic [CHW-1:0] cur_ch;

    cr_sequencer #(
        .NCH(NCH), .NRATE(NRATE), .NSW(NSW), .NCAL(NCAL), .AW(AW), .DW(DW),
        .TIMEOUT(TIMEOUT), .CAL_CTRL_ADDR(CAL_CTRL_ADDR),
        .CAL_STAT_ADDR(CAL_STAT_ADDR), .CAL_RES_BASE(CAL_RES_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cap_req(cap_req), .rep_req(rep_req), .rep_ch(rep_ch), .rep_rate(rep_rate),
        .prof_ch(prof_ch), .prof_rate(prof_rate), .prof_word(prof_word),
        .prof_addr(prof_addr), .prof_data(prof_data),
        .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .rsp_data(rsp_data),
        .ram_we(ram_we), .ram_idx(ram_idx), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .val_set(val_set), .val_clr(val_clr), .val_idx(val_idx), .val_in(val_in),
        .busy(busy), .cap_done(cap_done), .rep_done(rep_done),
        .rep_reject(rep_reject), .cal_err(cal_err), .chan_rst(chan_rst),
        .seq_rep(seq_rep), .cur_ch(cur_ch)
    );

    cr_record_ram #(.NREC(NREC), .DEPTH(DEPTH), .EW(EW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(ram_we), .idx(ram_idx), .wdata(ram_wdata), .rdata(ram_rdata),
        .vset(val_set), .vclr(val_clr), .vidx(val_idx), .vout(val_in)
    );

    cr_bus_master #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .rsp_data(rsp_data),
        .rc_addr(rc_addr), .rc_write(rc_write), .rc_read(rc_read), .rc_wdata(rc_wdata),
        .rc_waitreq(rc_waitreq), .rc_rdata(rc_rdata), .rc_rdvalid(rc_rdvalid)
    );

endmodule

// File: rtl/cr_checker.sv
module cr_checker #(
    parameter int AW            = 12,
    parameter int DW            = 32,
    parameter int NCH           = 2,
    parameter int CHW           = 1,
    parameter int CAL_CTRL_ADDR = 'h040
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  rc_addr,
    input logic [DW-1:0]  rc_wdata,
    input logic           rc_write,
    input logic           rc_read,
    input logic           rc_waitreq,
    input logic           seq_rep,
    input logic [CHW-1:0] cur_ch,
    input logic [NCH-1:0] chan_rst,
    input logic           busy,
    input logic           cap_done,
    input logic           rep_done,
    input logic           rep_reject,
    input logic           cal_err
);

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rc_write && rc_waitreq |=> rc_write && $stable(rc_addr) && $stable(rc_wdata)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rc_read && rc_waitreq |=> rc_read && $stable(rc_addr)); // R9
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rc_write && rc_read)); // R9
    AST_NO_CAL_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rep && rc_write |-> rc_addr != AW'(CAL_CTRL_ADDR)); // R5
    AST_NO_RD_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rep |-> !rc_read); // R5
    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rep && rc_write |-> chan_rst[cur_ch]); // R6
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done || rep_done || rep_reject || cal_err) |-> busy); // R4
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_done, rep_done, rep_reject, cal_err})); // R4
    AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !busy); // R4
    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rep_reject |=> chan_rst[$past(cur_ch)]); // R8
    AST_TOUT_END: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |=> !busy); // R7

endmodule

bind pll_calrec_ctrl cr_checker #(
    .AW(AW), .DW(DW), .NCH(NCH), .CHW(CHW), .CAL_CTRL_ADDR(CAL_CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rc_addr(rc_addr), .rc_wdata(rc_wdata),
    .rc_write(rc_write), .rc_read(rc_read), .rc_waitreq(rc_waitreq),
    .seq_rep(seq_rep), .cur_ch(cur_ch), .chan_rst(chan_rst), .busy(busy),
    .cap_done(cap_done), .rep_done(rep_done), .rep_reject(rep_reject), .cal_err(cal_err)
);

// File: tb/sim_pll_calrec_ctrl.sv
module sim_pll_calrec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_req = 1'b0, rep_req = 1'b0;
    logic [0:0]  rep_ch = '0, rep_rate = '0;
    logic [0:0]  prof_ch, prof_rate;
    logic [1:0]  prof_word;
    logic [11:0] prof_addr, rc_addr;
    logic [31:0] prof_data, rc_wdata;
    logic [31:0] rc_rdata = 32'hDEAD_BEEF;
    logic        rc_write, rc_read;
    logic        rc_waitreq = 1'b0, rc_rdvalid = 1'b0;
    logic        busy, cap_done, rep_done, rep_reject, cal_err;
    logic [1:0]  chan_rst;

    always #2.5 clk = ~clk;

    pll_calrec_ctrl #(.TIMEOUT(100)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .rep_req(rep_req),
        .rep_ch(rep_ch), .rep_rate(rep_rate),
        .prof_ch(prof_ch), .prof_rate(prof_rate), .prof_word(prof_word),
        .prof_addr(prof_addr), .prof_data(prof_data),
        .rc_addr(rc_addr), .rc_write(rc_write), .rc_read(rc_read), .rc_wdata(rc_wdata),
        .rc_waitreq(rc_waitreq), .rc_rdata(rc_rdata), .rc_rdvalid(rc_rdvalid),
        .busy(busy), .cap_done(cap_done), .rep_done(rep_done),
        .rep_reject(rep_reject), .cal_err(cal_err), .chan_rst(chan_rst)
    );

    function automatic logic [31:0] pdata(int ch, int rt, int w);
        return {8'hA0, 8'(ch), 8'(rt), 8'(w)};
    endfunction
    function automatic logic [31:0] calv(int ch, int rt, int k);
        return pdata(ch, rt, 0) + pdata(ch, rt, 1) + 32'(k) * 32'h11;
    endfunction

    assign prof_addr = 12'h010 + 12'(prof_word);
    assign prof_data = pdata(int'(prof_ch), int'(prof_rate), int'(prof_word));

    // PLL reconfiguration slave model
    logic [31:0] regs [256];
    logic [7:0]  lfsr = 8'h5A;
    int          cal_cnt = 0;
    logic        stuck = 1'b0;
    logic        p1 = 1'b0;
    logic [31:0] d1 = '0;
    wire         cal_busy = stuck || (cal_cnt != 0);

    always @(posedge clk) begin
        lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rc_waitreq <= lfsr[0] & lfsr[2];
        p1         <= 1'b0;
        if (cal_cnt != 0) cal_cnt <= cal_cnt - 1;
        if (cal_cnt == 1) begin
            for (int k = 0; k < 2; k++)
                regs[8'h50 + k] <= regs[8'h10] + regs[8'h11] + 32'(k) * 32'h11;
        end
        if (rc_write && !rc_waitreq) begin
            regs[rc_addr[7:0]] <= rc_wdata;
            if (rc_addr == 12'h040 && rc_wdata[0]) cal_cnt <= 7;
        end
        if (rc_read && !rc_waitreq) begin
            p1 <= 1'b1;
            d1 <= (rc_addr == 12'h041) ? {31'b0, cal_busy} : regs[rc_addr[7:0]];
        end
        rc_rdvalid <= p1;
        rc_rdata   <= p1 ? d1 : 32'hDEAD_BEEF;
    end

    // scoreboard
    int errs = 0, checks = 0;
    logic [43:0] expq[$];
    logic        in_rep = 1'b0;
    int          rch = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [11:0] a, logic [31:0] d);
        expq.push_back({a, d});
    endtask

    task automatic push_capture(int nch);
        for (int c = 0; c < nch; c++)
            for (int r = 0; r < 2; r++) begin
                for (int w = 0; w < 2; w++) push(12'h010 + 12'(w), pdata(c, r, w));
                push(12'h040, 32'd1);
            end
    endtask

    task automatic push_replay(int c, int r);
        for (int w = 0; w < 2; w++) push(12'h010 + 12'(w), pdata(c, r, w));
        for (int k = 0; k < 2; k++) push(12'h050 + 12'(k), calv(c, r, k));
    endtask

    always @(negedge clk) begin
        if (rst_n && rc_write && !rc_waitreq) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2/R5 unexpected write", {20'b0, rc_addr, rc_wdata}, 0);
            end else begin
                logic [43:0] e;
                e = expq.pop_front();
                chk({rc_addr, rc_wdata} == e, "R2/R3/R5 write", {20'b0, rc_addr, rc_wdata}, {20'b0, e});
            end
            if (in_rep) chk(chan_rst[rch], "R6 reset held in replay write", 64'(chan_rst), 64'(1 << rch));
        end
        if (rst_n && in_rep && rc_read)
            chk(1'b0, "R5 read during replay", 64'(rc_addr), 0);
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    bit s_cap, s_rep, s_rej, s_err;

    task automatic issue(bit cr, bit rr, int c, int r);
        @(negedge clk);
        cap_req = cr; rep_req = rr; rep_ch = 1'(c); rep_rate = 1'(r);
        @(negedge clk);
        cap_req = 1'b0; rep_req = 1'b0;
        chk(busy, "R4 busy after accept", 64'(busy), 1);
    endtask

    task automatic run_out();
        s_cap = 0; s_rep = 0; s_rej = 0; s_err = 0;
        for (int i = 0; i < 20000; i++) begin
            s_cap |= cap_done; s_rep |= rep_done; s_rej |= rep_reject; s_err |= cal_err;
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [1:0] snap;
        for (int i = 0; i < 256; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", 64'(busy), 0);
        chk(chan_rst == 2'b11, "R1 chan_rst", 64'(chan_rst), 3);
        chk(!rc_write && !rc_read, "R1 no command", 64'({rc_write, rc_read}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 replay before any capture, R1 records invalid
        issue(0, 1, 0, 0);
        run_out();
        chk(s_rej && !s_rep, "R8/R1 reject invalid", 64'({s_rej, s_rep}), 2);
        chk(chan_rst[0], "R8 reset left asserted", 64'(chan_rst), 3);
        chk(expq.size() == 0, "R8 no bus traffic", 64'(expq.size()), 0);

        // R11 simultaneous requests: capture wins
        push_capture(2);
        issue(1, 1, 0, 0);
        run_out();
        chk(s_cap && !s_rej && !s_rep, "R11 capture wins", 64'({s_cap, s_rej, s_rep}), 4);
        chk(s_cap, "R4 cap_done", 64'(s_cap), 1);
        chk(expq.size() == 0, "R2 capture sequence complete", 64'(expq.size()), 0);
        chk(chan_rst == 2'b11, "R11 chan_rst unchanged", 64'(chan_rst), 3);

        // R5/R6 replays
        for (int t = 0; t < 3; t++) begin
            int c, r;
            c = (t == 1) ? 1 : 0; r = (t == 0) ? 1 : (t == 1) ? 0 : 1;
            snap = chan_rst;
            push_replay(c, r);
            rch = c; in_rep = 1'b1;
            issue(0, 1, c, r);
            run_out();
            in_rep = 1'b0;
            chk(s_rep && !s_rej, "R5 rep_done", 64'({s_rep, s_rej}), 2);
            chk(!chan_rst[c], "R6 reset released", 64'(chan_rst), 0);
            chk(chan_rst[1-c] == snap[1-c], "R6 other channel unchanged", 64'(chan_rst), 64'(snap));
            chk(expq.size() == 0, "R3/R5 record replayed", 64'(expq.size()), 0);
        end

        // R10 request during capture ignored
        snap = chan_rst;
        push_capture(2);
        issue(1, 0, 0, 0);
        repeat (10) @(negedge clk);
        rep_req = 1'b1; rep_ch = 1'b0; rep_rate = 1'b1;
        @(negedge clk);
        rep_req = 1'b0;
        run_out();
        chk(s_cap && !s_rep && !s_rej, "R10 replay ignored while busy", 64'({s_cap, s_rep, s_rej}), 4);
        chk(chan_rst == snap, "R10 chan_rst untouched", 64'(chan_rst), 64'(snap));
        chk(expq.size() == 0, "R10 capture sequence", 64'(expq.size()), 0);

        // R7 timeout
        stuck = 1'b1;
        for (int w = 0; w < 2; w++) push(12'h010 + 12'(w), pdata(0, 0, w));
        push(12'h040, 32'd1);
        issue(1, 0, 0, 0);
        run_out();
        chk(s_err && !s_cap, "R7 timeout flagged", 64'({s_err, s_cap}), 2);
        chk(!busy, "R7 busy drops", 64'(busy), 0);
        chk(expq.size() == 0, "R7 traffic before timeout", 64'(expq.size()), 0);
        stuck = 1'b0;

        // R3/R8 aborted record invalid, channel reset asserted again
        issue(0, 1, 0, 0);
        run_out();
        chk(s_rej, "R3/R8 aborted record rejected", 64'(s_rej), 1);
        repeat (3) @(negedge clk);
        chk(chan_rst[0], "R8 chan_rst stays set", 64'(chan_rst), 1);

        // R3 untouched record still replays
        push_replay(1, 1);
        rch = 1; in_rep = 1'b1;
        issue(0, 1, 1, 1);
        run_out();
        in_rep = 1'b0;
        chk(s_rep, "R3 other record intact", 64'(s_rep), 1);
        chk(expq.size() == 0, "R5 replay after timeout", 64'(expq.size()), 0);
        chk(!chan_rst[1] && chan_rst[0], "R6 per-channel release", 64'(chan_rst), 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule